// File: doc/BRIEF.md
# Double-Buffered Period/Duty PWM Generator

This block produces a single pulse-width-modulated output. The period length comes from an 8-bit period register, scaled by a selectable clock divider of 1, 4 or 16. The pulse width comes from a 10-bit duty value. The time base is a 10-bit count: an 8-bit timer, with two fractional low bits below it. When the divider is 1:1, those two bits come from a four-phase clock counter. Otherwise they come from the upper two bits of the divider counter.

A host writes the period, the duty and the divider setting through a small register port, and it may do so at any moment. The duty it writes is not used directly. A shadow copy is taken only when a new period starts, so a write in the middle of a period cannot shorten or stretch the pulse in flight. The shadow copy can be read back but not written. A zero duty keeps the output low for the whole period. A duty longer than the period keeps the output high, because the clearing match is never reached.

Top module: `pwm_dbuf`

## Requirements
- R1: After reset, the output is low and the shadow duty reads 0. The write-side duty is 0, the period register holds 255 and the divider is 1:1.
- R2: The distance between two period starts is (P+1)·4·D clocks. P is the period register, written at address 0. D is the divider, selected by bits [1:0] of the control register at address 2: 0 gives 1, 1 gives 4, and 2 or 3 give 16.
- R3: At each period start with a nonzero duty, the output rises and stays high for exactly N·D clocks. N is the 10-bit duty: its upper 8 bits are written at address 1 and its lower 2 bits in control bits [3:2].
- R4: The shadow duty changes only at a period start. A duty write in the middle of a period leaves the shadow and the current pulse unchanged, and it takes effect from the next period.
- R5: With a duty of 0, the output never goes high.
- R6: With a duty greater than 4·(P+1)−1, the output, once high, stays high across period boundaries.
- R7: While enable is low, the output is low one clock later. A rising edge of enable starts a new period from count zero and loads the shadow from the current write-side duty.
- R8: Writes to address 3 change nothing. The shadow duty has no write path.
- R9: With P = 255 and a 1:1 divider, all 10 duty bits take effect: a duty of 1023 gives 1023 high clocks in a 1024-clock period.
- R10: Writing a different divider setting restarts the divider count, and the new ratio governs the following periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every count step is one clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Run enable; a rising edge starts a period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 period, 1 duty upper bits, 2 control |
| wr_data | input | 8 | Write data |
| duty_shadow | output | 10 | Read-back of the duty in use this period |
| pwm_out | output | 1 | PWM output |

## Verification
The bench builds the block with its default widths: an 8-bit timer and a 10-bit duty. Most scenarios use small period values, between 1 and 9, so that many periods and all three divider ratios fit in a few hundred clocks. One long run at period 255 covers every duty bit. The small periods also make it cheap to write a duty above the period, and to change the divider while the block is running.

// File: rtl/pwm_dbuf_pkg.sv
// Package: shared types and constants for the double-buffered PWM.
// Assumes the fractional time-base part is always two bits (four clock phases).
package pwm_dbuf_pkg;

    localparam int FRAC_W    = 2;  // fractional time-base bits
    localparam int MAX_SHIFT = 4;  // log2 of the largest divider (16)

    // Divider select codes, as written into control bits [1:0]
    typedef enum logic [1:0] {
        PS_DIV1   = 2'd0,
        PS_DIV4   = 2'd1,
        PS_DIV16  = 2'd2,
        PS_DIV16B = 2'd3
    } ps_e;

    localparam logic [1:0] ADDR_PERIOD  = 2'd0;
    localparam logic [1:0] ADDR_DUTY_HI = 2'd1;
    localparam logic [1:0] ADDR_CTRL    = 2'd2;

    // log2 of the divider ratio chosen by a select code
    function automatic int unsigned ps_shift(input ps_e sel);
        case (sel)
            PS_DIV1: return 0;
            PS_DIV4: return 2;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/pwm_regs.sv
// Module: pwm_regs
// Host-side register file. It holds the period, the write-side duty and the
// divider select. It also flags a write that changes the divider select.
// Assumes CNT_W >= 4, so that control bits [3:0] exist.
module pwm_regs
    import pwm_dbuf_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [1:0]                wr_addr,
    input  logic [CNT_W-1:0]          wr_data,
    output logic [CNT_W-1:0]          period,
    output logic [CNT_W+FRAC_W-1:0]   duty_wr,
    output ps_e                       ps_sel,
    output logic                      ps_chg
);
    localparam int DUTY_W = CNT_W + FRAC_W;

    // Register writes, decoded by address; address 3 is not decoded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period  <= '1;
            duty_wr <= '0;
            ps_sel  <= PS_DIV1;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_PERIOD:  period <= wr_data;
                ADDR_DUTY_HI: duty_wr[DUTY_W-1:FRAC_W] <= wr_data;
                ADDR_CTRL: begin
                    duty_wr[FRAC_W-1:0] <= wr_data[3:2];
                    ps_sel              <= ps_e'(wr_data[1:0]);
                end
                default: ;
            endcase
        end
    end

    // Flag a divider write whose code differs from the one in use.
    always_comb begin
        ps_chg = wr_en && (wr_addr == ADDR_CTRL) && (wr_data[1:0] != ps_sel);
    end

endmodule

// File: rtl/pwm_timebase.sv
// Module: pwm_timebase
// Divider counter plus 8-bit timer, forming a 10-bit time base. The module
// outputs the next-cycle value of the time base and a wrap flag, so that the
// output stage can act in the same edge.
// Assumes restart is a single-cycle pulse, and that en is high whenever
// restart is high.
module pwm_timebase
    import pwm_dbuf_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      en,
    input  logic                      restart,
    input  ps_e                       ps_sel,
    input  logic                      ps_chg,
    input  logic [CNT_W-1:0]          period,
    output logic                      wrap,
    output logic [CNT_W+FRAC_W-1:0]   tb_nxt,
    output logic [FRAC_W+MAX_SHIFT-1:0] pre_cnt
);
    localparam int PS_W = FRAC_W + MAX_SHIFT;

    logic [PS_W-1:0]  pre_q, pre_d, pre_lim, pre_sh;
    logic [CNT_W-1:0] tmr_q, tmr_d;
    logic             tick;

    // Last divider count before the timer steps: 4*ratio - 1.
    always_comb begin
        pre_lim = PS_W'((4 << ps_shift(ps_sel)) - 1);
        tick    = en && (pre_q == pre_lim);
        wrap    = tick && (tmr_q == period) && !restart;
    end

    // Next divider count: cleared on restart, on a divider change or on a tick.
    always_comb begin
        if (restart || ps_chg) pre_d = '0;
        else if (!en)          pre_d = pre_q;
        else if (tick)         pre_d = '0;
        else                   pre_d = pre_q + 1'b1;
    end

    // Next timer value: it steps on each tick and clears after matching the period.
    always_comb begin
        if (restart)   tmr_d = '0;
        else if (tick) tmr_d = (tmr_q == period) ? '0 : tmr_q + 1'b1;
        else           tmr_d = tmr_q;
    end

    // The fractional bits are the top two active bits of the divider count.
    always_comb begin
        pre_sh = pre_d >> ps_shift(ps_sel);
        tb_nxt = {tmr_d, pre_sh[FRAC_W-1:0]};
    end

    // Time-base state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            tmr_q <= '0;
        end else begin
            pre_q <= pre_d;
            tmr_q <= tmr_d;
        end
    end

    assign pre_cnt = pre_q;

endmodule

// File: rtl/pwm_outstage.sv
// Module: pwm_outstage
// Shadow duty register and output flop. At a period start it loads the shadow
// and sets the output, unless the new duty is zero. It clears the output on
// the edge where the time base reaches the shadow duty.
// Assumes tb_nxt is the time base value that will hold after this edge.
module pwm_outstage #(
    parameter int DUTY_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              period_start,
    input  logic [DUTY_W-1:0] duty_wr,
    input  logic [DUTY_W-1:0] tb_nxt,
    output logic [DUTY_W-1:0] duty_shadow,
    output logic              pwm_out
);
    // Shadow duty: copied from the write side only at a period start.
    always_ff @(posedge clk) begin
        if (!rst_n)            duty_shadow <= '0;
        else if (period_start) duty_shadow <= duty_wr;
    end

    // Output level: set at a period start, cleared on a compare match, low when off.
    always_ff @(posedge clk) begin
        if (!rst_n)                      pwm_out <= 1'b0;
        else if (!en)                    pwm_out <= 1'b0;
        else if (period_start)           pwm_out <= (duty_wr != '0);
        else if (tb_nxt == duty_shadow)  pwm_out <= 1'b0;
    end

endmodule

// File: rtl/pwm_dbuf.sv
// Module: pwm_dbuf (top)
// Double-buffered PWM generator: register port, 10-bit time base, and a
// shadowed duty compare driving one output.
// Assumes a synchronous, active-low reset, and a host that uses only
// addresses 0 to 2.
module pwm_dbuf
    import pwm_dbuf_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    wr_en,
    input  logic [1:0]              wr_addr,
    input  logic [CNT_W-1:0]        wr_data,
    output logic [CNT_W+FRAC_W-1:0] duty_shadow,
    output logic                    pwm_out
);
    localparam int DUTY_W = CNT_W + FRAC_W;
    localparam int PS_W   = FRAC_W + MAX_SHIFT;

    logic [CNT_W-1:0]  period;
    logic [DUTY_W-1:0] duty_wr, tb_nxt;
    logic [PS_W-1:0]   pre_cnt;
    ps_e               ps_sel;
    logic              ps_chg, wrap, en_q, en_rise, period_start;

    // Remember the previous enable, so that its rising edge can be seen.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en;
    end

    // A period starts on an enable rise or on a timer wrap.
    always_comb begin
        en_rise      = en && !en_q;
        period_start = en_rise || wrap;
    end

    pwm_regs #(.CNT_W(CNT_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .period  (period),
        .duty_wr (duty_wr),
        .ps_sel  (ps_sel),
        .ps_chg  (ps_chg)
    );

    pwm_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .restart (en_rise),
        .ps_sel  (ps_sel),
        .ps_chg  (ps_chg),
        .period  (period),
        .wrap    (wrap),
        .tb_nxt  (tb_nxt),
        .pre_cnt (pre_cnt)
    );

    pwm_outstage #(.DUTY_W(DUTY_W)) u_out (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (en),
        .period_start (period_start),
        .duty_wr      (duty_wr),
        .tb_nxt       (tb_nxt),
        .duty_shadow  (duty_shadow),
        .pwm_out      (pwm_out)
    );

endmodule

// File: rtl/pwm_dbuf_chk.sv
// Module: pwm_dbuf_chk
// Property checker bound to pwm_dbuf. It watches the period starts, the
// shadow, the output and the divider count.
// Assumes a synchronous, active-low reset.
module pwm_dbuf_chk
    import pwm_dbuf_pkg::*;
#(
    parameter int DUTY_W = 10,
    parameter int PS_W   = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              pwm_out,
    input logic [DUTY_W-1:0] duty_shadow,
    input logic              period_start,
    input logic [PS_W-1:0]   pre_cnt,
    input ps_e               ps_sel
);
    // R4
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !period_start |=> $stable(duty_shadow));

    // R7
    off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !pwm_out);

    // R3
    rise_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_out) |-> $past(period_start));

    // R5
    zero_duty_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        period_start |=> (pwm_out == (duty_shadow != '0)));

    // R10
    pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ps_sel == PS_DIV1) |-> (pre_cnt <= PS_W'(3)));

endmodule

bind pwm_dbuf pwm_dbuf_chk #(.DUTY_W(DUTY_W), .PS_W(PS_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (en),
    .pwm_out      (pwm_out),
    .duty_shadow  (duty_shadow),
    .period_start (period_start),
    .pre_cnt      (pre_cnt),
    .ps_sel       (ps_sel)
);

// File: tb/pwm_dbuf_bench.sv
module pwm_dbuf_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [9:0] duty_shadow;
    logic       pwm_out;
    int         n_chk = 0;
    int         n_fail = 0;

    always #2 clk = ~clk;

    pwm_dbuf u_pwm_dbuf (
        .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .duty_shadow(duty_shadow), .pwm_out(pwm_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_duty(input int d, input int ps);
        wr(2'd1, 8'(d >> 2));
        wr(2'd2, 8'({d[1:0], ps[1:0]}));
    endtask

    // Wait for the next rise, then count the high clocks and the whole period.
    task automatic measure(output int hi, output int per);
        int   guard = 0;
        logic prev;
        prev = pwm_out;
        @(negedge clk);
        while (!(prev == 1'b0 && pwm_out == 1'b1) && guard < 5000) begin
            prev = pwm_out; @(negedge clk); guard++;
        end
        hi = 0;
        while (pwm_out && guard < 5000) begin hi++; @(negedge clk); guard++; end
        per = hi;
        while (!pwm_out && guard < 5000) begin per++; @(negedge clk); guard++; end
    endtask

    task automatic count_high(input int n, output int h);
        h = 0;
        for (int i = 0; i < n; i++) begin
            if (pwm_out) h++;
            @(negedge clk);
        end
    endtask

    task automatic configure(input int pr, input int duty, input int ps);
        en = 1'b0;
        @(negedge clk);
        wr(2'd0, 8'(pr));
        set_duty(duty, ps);
        en = 1'b1;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(pwm_out == 1'b0, "R1 out", pwm_out, 0);
        check(duty_shadow == 10'd0, "R1 shadow", duty_shadow, 0);
        en = 1'b1;               // reset write-side duty is 0, so the output stays low
        @(negedge clk);
        check(duty_shadow == 10'd0, "R1 duty_wr", duty_shadow, 0);
        en = 1'b0;
    endtask

    task automatic t_basic_and_buffer;
        int hi, per;
        configure(9, 20, 0);
        measure(hi, per);
        check(hi == 20, "R3 high ps1", hi, 20);
        check(per == 40, "R2 period ps1", per, 40);
        set_duty(8, 0);          // mid-period write
        check(duty_shadow == 10'd20, "R4 shadow held", duty_shadow, 20);
        measure(hi, per);
        check(hi == 8, "R4 next period", hi, 8);
        check(duty_shadow == 10'd8, "R4 shadow loaded", duty_shadow, 8);
        wr(2'd3, 8'hFF);         // unused address
        check(duty_shadow == 10'd8, "R8 shadow", duty_shadow, 8);
        measure(hi, per);
        check(hi == 8 && per == 40, "R8 output", hi, 8);
    endtask

    task automatic t_dividers;
        int hi, per;
        configure(4, 6, 1);
        measure(hi, per);
        check(hi == 24, "R3 high ps4", hi, 24);
        check(per == 80, "R2 period ps4", per, 80);
        configure(1, 3, 2);
        measure(hi, per);
        check(hi == 48, "R3 high ps16", hi, 48);
        check(per == 128, "R2 period ps16", per, 128);
    endtask

    task automatic t_ps_change;
        int hi, per;
        configure(1, 4, 0);
        measure(hi, per);
        check(per == 8, "R10 before", per, 8);
        wr(2'd2, 8'h01);         // duty low bits 0, divider 1:4
        measure(hi, per);
        measure(hi, per);
        check(hi == 16, "R10 high after", hi, 16);
        check(per == 32, "R10 period after", per, 32);
    endtask

    task automatic t_zero_and_over;
        int h;
        configure(3, 0, 0);
        @(negedge clk);
        count_high(100, h);
        check(h == 0, "R5 zero duty", h, 0);
        configure(3, 100, 0);
        @(negedge clk);
        count_high(100, h);
        check(h == 100, "R6 over period", h, 100);
        en = 1'b0;
        @(negedge clk);
        check(pwm_out == 1'b0, "R7 disable", pwm_out, 0);
        count_high(20, h);
        check(h == 0, "R7 stays low", h, 0);
    endtask

    task automatic t_enable_load;
        int hi, per;
        configure(9, 12, 0);
        @(negedge clk);
        check(duty_shadow == 10'd12, "R7 load on enable", duty_shadow, 12);
        check(pwm_out == 1'b1, "R7 first pulse", pwm_out, 1);
    endtask

    task automatic t_full_res;
        int hi, per;
        configure(255, 1023, 0);
        measure(hi, per);
        check(hi == 1023, "R9 high", hi, 1023);
        check(per == 1024, "R9 period", per, 1024);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_basic_and_buffer();
        t_dividers();
        t_ps_change();
        t_zero_and_over();
        t_enable_load();
        t_full_res();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule